// File: doc/BRIEF.md
# Receive Message Object Allocator

This block owns a bank of receive message objects inside a CAN controller and decides, for each frame that the bus side has already accepted, which object stores it. Every object holds a filter (identifier, mask, use-mask flag), a valid bit, a direction bit, a receive-interrupt enable and an end-of-buffer marker. It also holds three status flags: new-data, message-lost and interrupt-pending. Objects whose filters accept the same frames and sit below an object carrying the end-of-buffer marker form a FIFO chain. A frame lands in the lowest free object of that chain. When the chain is full, the frame overwrites the terminating object and flags the loss.

Software configures an object through a write port and clears its flags through a separate clear port. It reads back the stored identifier of any object. The flag vectors and an interrupt identifier are always visible. The identifier reports a status interrupt first. Otherwise it gives the lowest-numbered object with a pending interrupt.

Top module: `rx_obj_alloc`

## Requirements
- R1: An object is eligible for a frame only when its valid bit is 1, its direction bit is 0 (receive), and (frame id XOR object id) AND effective mask is zero. The effective mask is the stored mask when use-mask is 1 and all ones otherwise. A frame that no object accepts changes no flag and no stored identifier.
- R2: Objects are scanned upward from object 1. The frame goes to the first eligible object whose new-data flag is 0. The scan ends at the first eligible object whose end-of-buffer bit is 1.
- R3: Storing a frame sets the object's new-data flag and records the frame identifier, which is readable on rd_id when rd_obj holds that object's number. Interrupt-pending is set only if the object's receive-interrupt enable is 1.
- R4: If every eligible object up to and including the first end-of-buffer object has new-data set, the frame overwrites that end-of-buffer object and sets its message-lost flag.
- R5: If every eligible object has new-data set and none of them carries the end-of-buffer bit, the frame is discarded.
- R6: int_id is 16'h8000 while status_irq is 1. Otherwise it is the number of the lowest object with interrupt-pending set, or 0 when none is pending. The value is combinational from current state.
- R7: In newdat_vec, msglst_vec and intpnd_vec, bit n-1 belongs to object n. Object numbers on cfg_obj, clr_obj and rd_obj run from 1 to NUM_OBJ.
- R8: A clear request for object n lowers each flag whose clear bit is 1, one cycle later. An object with new-data cleared is free for allocation again.
- R9: When a clear and a frame arrive in the same cycle, allocation uses the flags as they were before the clear. If both hit the same object, the store's flag settings win.
- R10: Reset leaves every object invalid and every flag 0. A configuration write loads all object fields and zeroes its three flags, and it takes precedence over a store to the same object.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_obj | input | OBJ_W | Object number to configure |
| cfg_valid | input | 1 | Object valid |
| cfg_xmit | input | 1 | Direction, 1 = transmit |
| cfg_umask | input | 1 | Use mask for filtering |
| cfg_eob | input | 1 | End-of-buffer marker |
| cfg_rxie | input | 1 | Receive interrupt enable |
| cfg_id | input | ID_W | Filter identifier |
| cfg_mask | input | ID_W | Filter mask, 1 = bit compared |
| clr_we | input | 1 | Flag clear strobe |
| clr_obj | input | OBJ_W | Object number to clear |
| clr_newdat | input | 1 | Clear new-data |
| clr_intpnd | input | 1 | Clear interrupt-pending |
| clr_msglst | input | 1 | Clear message-lost |
| frm_valid | input | 1 | Accepted frame present this cycle |
| frm_id | input | ID_W | Frame identifier |
| status_irq | input | 1 | Status interrupt request |
| rd_obj | input | OBJ_W | Object number to read back |
| rd_id | output | ID_W | Stored identifier of rd_obj |
| newdat_vec | output | NUM_OBJ | New-data flags |
| msglst_vec | output | NUM_OBJ | Message-lost flags |
| intpnd_vec | output | NUM_OBJ | Interrupt-pending flags |
| int_id | output | 16 | Interrupt identifier |

## Verification
A software flag clear and an incoming frame can land in the same cycle, and the bench provokes this in two ways. In the first, the cleared object lies inside a full chain, so the frame still overwrites the end-of-buffer object while the cleared object stays empty. In the second, the clear targets the very object the allocator picks, and the bench expects the store to leave new-data set with the new identifier. Each outcome is judged from the flag vectors and from rd_id one cycle later.

// File: rtl/rx_obj_alloc.sv
module rx_obj_alloc #(
  parameter int NUM_OBJ = 16,
  parameter int ID_W    = 29,
  parameter int OBJ_W   = $clog2(NUM_OBJ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [OBJ_W-1:0]   cfg_obj,
  input  logic               cfg_valid,
  input  logic               cfg_xmit,
  input  logic               cfg_umask,
  input  logic               cfg_eob,
  input  logic               cfg_rxie,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [ID_W-1:0]    cfg_mask,
  input  logic               clr_we,
  input  logic [OBJ_W-1:0]   clr_obj,
  input  logic               clr_newdat,
  input  logic               clr_intpnd,
  input  logic               clr_msglst,
  input  logic               frm_valid,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               status_irq,
  input  logic [OBJ_W-1:0]   rd_obj,
  output logic [ID_W-1:0]    rd_id,
  output logic [NUM_OBJ-1:0] newdat_vec,
  output logic [NUM_OBJ-1:0] msglst_vec,
  output logic [NUM_OBJ-1:0] intpnd_vec,
  output logic [15:0]        int_id
);
  localparam logic [15:0] STATUS_CODE = 16'h8000;

  logic [NUM_OBJ-1:0] val_q, xmit_q, umask_q, eob_q, rxie_q;
  logic [NUM_OBJ-1:0] nd_q, ml_q, ip_q;
  logic [ID_W-1:0]    fid_q  [NUM_OBJ];
  logic [ID_W-1:0]    fmsk_q [NUM_OBJ];
  logic [ID_W-1:0]    sid_q  [NUM_OBJ];
  logic [NUM_OBJ-1:0] elig;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_match
    logic [ID_W-1:0] eff_mask;
    assign eff_mask = umask_q[g] ? fmsk_q[g] : '1;
    assign elig[g]  = val_q[g] && !xmit_q[g] &&
                      (((frm_id ^ fid_q[g]) & eff_mask) == '0);
  end

  logic             hit;
  logic [OBJ_W-1:0] tgt;
  always_comb begin
    logic stop;
    stop = 1'b0;
    hit  = 1'b0;
    tgt  = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (!stop && elig[i]) begin
        if (!nd_q[i]) begin
          hit  = 1'b1;
          tgt  = OBJ_W'(i + 1);
          stop = 1'b1;
        end else if (eob_q[i]) begin
          hit  = 1'b1;
          tgt  = OBJ_W'(i + 1);
          stop = 1'b1;
        end
      end
    end
    hit = hit && frm_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0; xmit_q <= '0; umask_q <= '0; eob_q <= '0; rxie_q <= '0;
      nd_q  <= '0; ml_q   <= '0; ip_q    <= '0;
      for (int i = 0; i < NUM_OBJ; i++) begin
        fid_q[i]  <= '0;
        fmsk_q[i] <= '0;
        sid_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_OBJ; i++) begin
        if (cfg_we && cfg_obj == OBJ_W'(i + 1)) begin
          val_q[i]   <= cfg_valid;
          xmit_q[i]  <= cfg_xmit;
          umask_q[i] <= cfg_umask;
          eob_q[i]   <= cfg_eob;
          rxie_q[i]  <= cfg_rxie;
          fid_q[i]   <= cfg_id;
          fmsk_q[i]  <= cfg_mask;
          nd_q[i]    <= 1'b0;
          ml_q[i]    <= 1'b0;
          ip_q[i]    <= 1'b0;
        end else begin
          if (clr_we && clr_obj == OBJ_W'(i + 1)) begin
            if (clr_newdat) nd_q[i] <= 1'b0;
            if (clr_intpnd) ip_q[i] <= 1'b0;
            if (clr_msglst) ml_q[i] <= 1'b0;
          end
          if (hit && tgt == OBJ_W'(i + 1)) begin
            nd_q[i]  <= 1'b1;
            sid_q[i] <= frm_id;
            if (rxie_q[i]) ip_q[i] <= 1'b1;
            if (nd_q[i])   ml_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    int_id = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--)
      if (ip_q[i]) int_id = 16'(i + 1);
    if (status_irq) int_id = STATUS_CODE;
  end

  always_comb begin
    rd_id = '0;
    for (int i = 0; i < NUM_OBJ; i++)
      if (rd_obj == OBJ_W'(i + 1)) rd_id = sid_q[i];
  end

  assign newdat_vec = nd_q;
  assign msglst_vec = ml_q;
  assign intpnd_vec = ip_q;

  // R2: at most one object becomes full per frame
  a_r2_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(newdat_vec & ~$past(newdat_vec)) <= 1);

  // R1: a new-data flag only rises after a frame was presented
  a_r1_fill_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ((newdat_vec & ~$past(newdat_vec)) != '0) |-> $past(frm_valid));

  // R6: object identifier names a pending object with nothing lower pending
  a_r6_lowest_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id != 16'd0 && int_id != STATUS_CODE) |->
      ((intpnd_vec & (NUM_OBJ'(1) << (int_id - 16'd1))) != '0 &&
       (intpnd_vec & ((NUM_OBJ'(1) << (int_id - 16'd1)) - NUM_OBJ'(1))) == '0));

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_chk
    // R4: message-lost rises only when a full object takes a frame
    a_r4_lost_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msglst_vec[g]) |-> ($past(newdat_vec[g]) && $past(frm_valid)));
  end
endmodule

// File: tb/rx_obj_alloc_tb.sv
module rx_obj_alloc_tb;
  localparam int NUM_OBJ = 16;
  localparam int ID_W    = 29;
  localparam int OBJ_W   = $clog2(NUM_OBJ + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               cfg_we = 0, cfg_valid = 0, cfg_xmit = 0, cfg_umask = 0, cfg_eob = 0, cfg_rxie = 0;
  logic [OBJ_W-1:0]   cfg_obj = '0, clr_obj = '0, rd_obj = '0;
  logic [ID_W-1:0]    cfg_id = '0, cfg_mask = '0, frm_id = '0;
  logic               clr_we = 0, clr_newdat = 0, clr_intpnd = 0, clr_msglst = 0;
  logic               frm_valid = 0, status_irq = 0;
  logic [ID_W-1:0]    rd_id;
  logic [NUM_OBJ-1:0] newdat_vec, msglst_vec, intpnd_vec;
  logic [15:0]        int_id;

  rx_obj_alloc #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_obj(cfg_obj), .cfg_valid(cfg_valid), .cfg_xmit(cfg_xmit),
    .cfg_umask(cfg_umask), .cfg_eob(cfg_eob), .cfg_rxie(cfg_rxie),
    .cfg_id(cfg_id), .cfg_mask(cfg_mask),
    .clr_we(clr_we), .clr_obj(clr_obj), .clr_newdat(clr_newdat),
    .clr_intpnd(clr_intpnd), .clr_msglst(clr_msglst),
    .frm_valid(frm_valid), .frm_id(frm_id), .status_irq(status_irq),
    .rd_obj(rd_obj), .rd_id(rd_id),
    .newdat_vec(newdat_vec), .msglst_vec(msglst_vec), .intpnd_vec(intpnd_vec),
    .int_id(int_id)
  );

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [15:0]     nd;
    logic [15:0]     ml;
    logic [15:0]     ip;
    logic [15:0]     iid;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{29'h123, 16'h0001, 16'h0000, 16'h0001, 16'd1},
    '{29'h1AB, 16'h0003, 16'h0000, 16'h0003, 16'd1},
    '{29'h777, 16'h0003, 16'h0000, 16'h0003, 16'd1},
    '{29'h150, 16'h0007, 16'h0000, 16'h0003, 16'd1},
    '{29'h055, 16'h0017, 16'h0000, 16'h0013, 16'd1},
    '{29'h160, 16'h001F, 16'h0000, 16'h001B, 16'd1},
    '{29'h170, 16'h001F, 16'h0008, 16'h001B, 16'd1},
    '{29'h056, 16'h001F, 16'h0008, 16'h001B, 16'd1},
    '{29'h055, 16'h001F, 16'h0018, 16'h001B, 16'd1},
    '{29'h300, 16'h001F, 16'h0018, 16'h001B, 16'd1},
    '{29'h301, 16'h001F, 16'h0018, 16'h001B, 16'd1}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int obj, input logic v, input logic x, input logic um,
                     input logic eb, input logic ie, input logic [ID_W-1:0] id,
                     input logic [ID_W-1:0] mk);
    @(negedge clk);
    cfg_we = 1; cfg_obj = OBJ_W'(obj); cfg_valid = v; cfg_xmit = x; cfg_umask = um;
    cfg_eob = eb; cfg_rxie = ie; cfg_id = id; cfg_mask = mk;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic frame(input logic [ID_W-1:0] id);
    @(negedge clk);
    frm_valid = 1; frm_id = id;
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic clear(input int obj, input logic nd, input logic ip, input logic ml);
    @(negedge clk);
    clr_we = 1; clr_obj = OBJ_W'(obj); clr_newdat = nd; clr_intpnd = ip; clr_msglst = ml;
    @(negedge clk);
    clr_we = 0;
  endtask

  task automatic clear_with_frame(input int obj, input logic [ID_W-1:0] id);
    @(negedge clk);
    clr_we = 1; clr_obj = OBJ_W'(obj); clr_newdat = 1; clr_intpnd = 0; clr_msglst = 0;
    frm_valid = 1; frm_id = id;
    @(negedge clk);
    clr_we = 0; frm_valid = 0;
  endtask

  task automatic read_id(input int obj, input logic [ID_W-1:0] exp, input string tag);
    rd_obj = OBJ_W'(obj);
    #1;
    check(tag, 64'(rd_id), 64'(exp));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state, R6 nothing pending
    check("R10 reset newdat", 64'(newdat_vec), 64'h0);
    check("R10 reset msglst", 64'(msglst_vec), 64'h0);
    check("R10 reset intpnd", 64'(intpnd_vec), 64'h0);
    check("R6 idle int_id", 64'(int_id), 64'h0);

    // FIFO chain objects 1..4 (obj3 without rx interrupt), single obj 5,
    // transmit obj 6, invalid obj 7
    cfg(1, 1, 0, 1, 0, 1, 29'h100, 29'h1FFFFF00);
    cfg(2, 1, 0, 1, 0, 1, 29'h100, 29'h1FFFFF00);
    cfg(3, 1, 0, 1, 0, 0, 29'h100, 29'h1FFFFF00);
    cfg(4, 1, 0, 1, 1, 1, 29'h100, 29'h1FFFFF00);
    cfg(5, 1, 0, 0, 1, 1, 29'h055, 29'h0);
    cfg(6, 1, 1, 0, 1, 1, 29'h300, 29'h0);
    cfg(7, 0, 0, 0, 1, 1, 29'h301, 29'h0);

    // table walk: R1 filtering, R2 lowest free, R3 flags, R4 overwrite, R7 bit map
    for (int k = 0; k < NV; k++) begin
      frame(VT[k].id);
      check($sformatf("R2 R7 vec%0d newdat", k), 64'(newdat_vec), 64'(VT[k].nd));
      check($sformatf("R4 vec%0d msglst", k), 64'(msglst_vec), 64'(VT[k].ml));
      check($sformatf("R3 vec%0d intpnd", k), 64'(intpnd_vec), 64'(VT[k].ip));
      check($sformatf("R6 vec%0d int_id", k), 64'(int_id), 64'(VT[k].iid));
    end
    read_id(1, 29'h123, "R3 stored id obj1");
    read_id(4, 29'h170, "R4 overwritten id obj4");
    read_id(3, 29'h150, "R3 stored id obj3");

    // R6 status outranks objects
    status_irq = 1; #1;
    check("R6 status code", 64'(int_id), 64'h8000);
    status_irq = 0; #1;
    check("R6 back to object", 64'(int_id), 64'd1);

    // R8 clear interrupt-pending on 1 and 2
    clear(1, 0, 1, 0);
    clear(2, 0, 1, 0);
    check("R8 intpnd cleared", 64'(intpnd_vec), 64'h0018);
    check("R6 lowest pending obj4", 64'(int_id), 64'd4);

    // R8 free object 2 again and refill it
    clear(2, 1, 0, 0);
    check("R8 newdat cleared", 64'(newdat_vec), 64'h001D);
    frame(29'h1FF);
    check("R8 refill newdat", 64'(newdat_vec), 64'h001F);
    check("R8 refill msglst", 64'(msglst_vec), 64'h0018);
    check("R3 refill intpnd", 64'(intpnd_vec), 64'h001A);
    check("R6 refill int_id", 64'(int_id), 64'd2);
    read_id(2, 29'h1FF, "R8 refill id obj2");

    // R9 clear inside full chain with simultaneous frame
    clear_with_frame(3, 29'h101);
    check("R9 pre-clear decision newdat", 64'(newdat_vec), 64'h001B);
    check("R9 pre-clear decision msglst", 64'(msglst_vec), 64'h0018);
    read_id(4, 29'h101, "R9 overwrite obj4");

    // R9 clear and store on the same object: store wins
    clear_with_frame(3, 29'h102);
    check("R9 store wins newdat", 64'(newdat_vec), 64'h001F);
    read_id(3, 29'h102, "R9 store wins id");

    // R10 reconfiguration clears flags; obj5 now lacks end-of-buffer
    cfg(5, 1, 0, 1, 0, 1, 29'h050, 29'h1FFFFFF0);
    check("R10 cfg clears newdat", 64'(newdat_vec), 64'h000F);
    check("R10 cfg clears msglst", 64'(msglst_vec), 64'h0008);
    check("R10 cfg clears intpnd", 64'(intpnd_vec), 64'h000A);

    // R5 full object without end-of-buffer discards the frame
    frame(29'h055);
    check("R5 first store newdat", 64'(newdat_vec), 64'h001F);
    frame(29'h05A);
    check("R5 discard msglst", 64'(msglst_vec), 64'h0008);
    check("R5 discard newdat", 64'(newdat_vec), 64'h001F);
    read_id(5, 29'h055, "R5 discard keeps id");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule